// File: doc/BRIEF.md
# Compare-Clear Interval Timer

This block is a 16-bit up-counter that advances on single-cycle enables taken from a free-running prescaler. The prescaler runs off the system clock or off an external low-frequency enable. Software loads a compare value. When the next increment would make the count equal to that value, the counter returns to zero instead, a one-cycle interrupt pulse goes out and counting carries on. The result is a periodic interrupt every *compare* ticks of the chosen source, with no reload by software.

The control word is write-only, so every write replaces the whole word. One bit runs the counter. A two-bit field picks the tick source. A further bit is a capture strobe: when a write carries it, the running count is copied into a readable capture register, and the counter does not pause. The strobe is acted on only in the write cycle and is never stored, so it behaves as a bit that clears itself. The compare and capture registers are read back through a registered read port.

Top module: `cmpclr_timer`

## Requirements
- R1: After reset, irq is 0 and reads of the compare register (address 1) and the capture register (address 2) both return 0.
- R2: While the run bit (control bit 4) is 1, the count rises by exactly one on each tick of the selected source. It never changes in any other way except to return to 0.
- R3: On a tick where the count plus one equals the compare value, the count becomes 0 and irq is high for exactly one cycle. Interrupts are therefore spaced by compare × (source period) system cycles.
- R4: After a match the counter continues from 0 by itself, so interrupts repeat at the same spacing without any further write.
- R5: Control bits [1:0] select the tick source as follows: 0 gives one tick per 2048 system clocks, 1 gives one per 128, 2 gives one per 8, and 3 gives one tick per 8 pulses of slow_tick.
- R6: A control write with bit 6 set copies the count held before that clock edge into the capture register. The count and the interrupt timing are not disturbed.
- R7: The capture strobe is not retained. A later control write with bit 6 clear leaves the capture register unchanged.
- R8: A control write with bit 4 clear stops the counter and forces the count to 0, and no interrupt occurs while stopped.
- R9: rd_data is registered and is valid one cycle after rd_addr is sampled. Address 0 (control) and address 3 read as 0.
- R10: Writes to the capture address (2) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable from a low-frequency clock domain already in clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 compare, 2 capture (ignored) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | One-cycle pulse on each compare match |

## Verification
The bench measures the spacing between consecutive interrupts for every tick source, including a compare value of 1. A design whose match test is one tick late or early, or that wires the source taps wrongly, gives a different spacing. Captures are taken a fixed number of cycles after an interrupt. Each capture must return the number of ticks elapsed, and the following interrupt must keep its spacing: a capture that stalls or resets the counter shifts that interrupt. The bench also checks that a stopped counter both captures 0 and stays silent. It checks that a control write without the strobe, or a write to the capture address, leaves the captured value alone, which catches a design that latches the strobe or decodes the capture address as writable.

// File: rtl/cmpclr_pkg.sv
package cmpclr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CAP  = 2'd2;
  localparam int B_RUN = 4;
  localparam int B_CAP = 6;

  typedef enum logic [1:0] {
    SRC_COARSE = 2'd0,
    SRC_MID    = 2'd1,
    SRC_FINE   = 2'd2,
    SRC_SLOW   = 2'd3
  } src_e;
endpackage

// File: rtl/cmpclr_prescale.sv
module cmpclr_prescale #(
  parameter int COARSE_LOG2 = 11,
  parameter int MID_LOG2    = 7,
  parameter int FINE_LOG2   = 3,
  parameter int SLOW_LOG2   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_en,
  input  cmpclr_pkg::src_e sel,
  output logic             tick
);
  import cmpclr_pkg::*;

  logic [COARSE_LOG2-1:0] div_q;
  logic tap_c, tap_m, tap_f, tap_s;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tap_c = &div_q[COARSE_LOG2-1:0];
  assign tap_m = &div_q[MID_LOG2-1:0];
  assign tap_f = &div_q[FINE_LOG2-1:0];

  generate
    if (SLOW_LOG2 == 0) begin : g_slow_direct
      assign tap_s = slow_en;
    end else begin : g_slow_div
      logic [SLOW_LOG2-1:0] slow_q;
      always_ff @(posedge clk) begin
        if (rst)          slow_q <= '0;
        else if (slow_en) slow_q <= slow_q + 1'b1;
      end
      assign tap_s = slow_en && (&slow_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else begin
      unique case (sel)
        SRC_COARSE: tick <= tap_c;
        SRC_MID:    tick <= tap_m;
        SRC_FINE:   tick <= tap_f;
        default:    tick <= tap_s;
      endcase
    end
  end
endmodule

// File: rtl/cmpclr_count.sv
module cmpclr_count #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic [DATA_W-1:0] cmp,
  output logic [DATA_W-1:0] count,
  output logic              irq
);
  logic [DATA_W-1:0] count_nx;
  logic              hit;

  assign count_nx = count + 1'b1;
  assign hit      = (count_nx == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!run) begin
        count <= '0;
      end else if (tick) begin
        if (hit) begin
          count <= '0;
          irq   <= 1'b1;
        end else begin
          count <= count_nx;
        end
      end
    end
  end
endmodule

// File: rtl/cmpclr_regs.sv
module cmpclr_regs #(
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [cmpclr_pkg::ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [cmpclr_pkg::ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]               count,
  output logic                            run,
  output cmpclr_pkg::src_e                sel,
  output logic [DATA_W-1:0]               cmp,
  output logic [DATA_W-1:0]               cap,
  output logic [DATA_W-1:0]               rd_data
);
  import cmpclr_pkg::*;

  logic ctrl_wr, cap_strobe;

  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);
  assign cap_strobe = ctrl_wr && wr_data[B_CAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      sel <= SRC_COARSE;
    end else if (ctrl_wr) begin
      run <= wr_data[B_RUN];
      sel <= src_e'(wr_data[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             cmp <= '0;
    else if (wr_en && wr_addr == A_CMP)  cmp <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)             cap <= '0;
    else if (cap_strobe) cap <= count;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_addr)
        A_CMP:   rd_data <= cmp;
        A_CAP:   rd_data <= cap;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmpclr_timer.sv
module cmpclr_timer #(
  parameter int DATA_W      = 16,
  parameter int COARSE_LOG2 = 11,
  parameter int MID_LOG2    = 7,
  parameter int FINE_LOG2   = 3,
  parameter int SLOW_LOG2   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          slow_tick,
  input  logic                          wr_en,
  input  logic [cmpclr_pkg::ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [cmpclr_pkg::ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          irq
);
  import cmpclr_pkg::*;

  logic              run_w, tick_w;
  src_e              sel_w;
  logic [DATA_W-1:0] cmp_w, cap_w, count_w;

  cmpclr_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .count(count_w),
    .run(run_w), .sel(sel_w), .cmp(cmp_w), .cap(cap_w), .rd_data(rd_data)
  );

  cmpclr_prescale #(
    .COARSE_LOG2(COARSE_LOG2), .MID_LOG2(MID_LOG2),
    .FINE_LOG2(FINE_LOG2), .SLOW_LOG2(SLOW_LOG2)
  ) pre_i (
    .clk(clk), .rst(rst), .slow_en(slow_tick), .sel(sel_w), .tick(tick_w)
  );

  cmpclr_count #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst(rst), .run(run_w), .tick(tick_w),
    .cmp(cmp_w), .count(count_w), .irq(irq)
  );
endmodule

// File: rtl/cmpclr_chk.sv
module cmpclr_chk #(
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [cmpclr_pkg::ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0]             wr_data,
  input logic [cmpclr_pkg::ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0]             rd_data,
  input logic                          irq,
  input logic                          run,
  input logic                          tick,
  input logic [DATA_W-1:0]             count,
  input logic [DATA_W-1:0]             cap
);
  import cmpclr_pkg::*;

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));

  p_irq_clears_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (count == '0));

  p_irq_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(run && tick));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));

  p_cap_only_on_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (cap != $past(cap)) |-> $past(wr_en && wr_addr == A_CTRL && wr_data[B_CAP]));

  p_ctrl_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr == A_CTRL) |-> (rd_data == '0));
endmodule

bind cmpclr_timer cmpclr_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .run(run_w),
  .tick(tick_w), .count(count_w), .cap(cap_w)
);

// File: tb/cmpclr_timer_tb.sv
module cmpclr_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        irq;

  int     n_checks = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  cmpclr_timer dut_i (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic wait_irq(output longint t);
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!irq && n < 20000);
    t = cyc;
    if (!irq) begin
      n_checks++; n_fail++;
      $display("FAIL R3 actual=no_irq expected=irq");
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", irq, 0);
    rd(2'd1, v); check("R1 cmp", v, 0);
    rd(2'd2, v); check("R1 cap", v, 0);
  endtask

  task automatic t_period(input string tag, input logic [1:0] sel,
                          input logic [15:0] cmpv, input longint exp);
    longint t0, t1, t2;
    wr(2'd1, cmpv);
    wr(2'd0, 16'h0010 | {14'd0, sel});
    wait_irq(t0);
    wait_irq(t1);
    if (exp > 1) begin
      @(negedge clk);
      check({tag, " R3 pulse width"}, irq, 0);
    end
    wait_irq(t2);
    check({tag, " R3 period"}, t2 - t1, exp);
    wait_irq(t0);
    check({tag, " R4 repeat"}, t0 - t2, exp);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    longint t0, t1;
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0012);
    wait_irq(t0);
    wait_irq(t0);
    repeat (19) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0052;
    @(negedge clk); wr_en = 1'b0;
    wait_irq(t1);
    check("R6 irq spacing kept", t1 - t0, 80);
    rd(2'd2, v); check("R6 captured count", v, 2);
    check("R2 count from capture", v, 2);
    wr(2'd0, 16'h0012);
    rd(2'd2, v); check("R7 no capture without strobe", v, 2);
    wr(2'd2, 16'hBEEF);
    rd(2'd2, v); check("R10 capture write ignored", v, 2);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    int seen = 0;
    wr(2'd0, 16'h0002);
    repeat (4) @(negedge clk);
    wr(2'd0, 16'h0042);
    rd(2'd2, v); check("R8 stopped count", v, 0);
    repeat (300) begin
      @(negedge clk);
      if (irq) seen++;
    end
    check("R8 no irq when stopped", seen, 0);
  endtask

  task automatic t_reads();
    logic [15:0] v;
    wr(2'd1, 16'h1234);
    rd(2'd1, v); check("R9 compare readback", v, 16'h1234);
    rd(2'd0, v); check("R9 control reads 0", v, 0);
    rd(2'd3, v); check("R9 addr3 reads 0", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_period("R5 fine", 2'd2, 16'd5, 40);
    t_period("R5 fine cmp1", 2'd2, 16'd1, 8);
    t_period("R5 mid", 2'd1, 16'd3, 384);
    t_period("R5 coarse", 2'd0, 16'd2, 4096);
    t_period("R5 slow", 2'd3, 16'd3, 96);
    t_capture();
    t_stop();
    t_reads();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule